// File: doc/BRIEF.md
# Indirect Configuration Access Window

This block gives a host processor a two-register window for configuration reads and writes on a PCI-style bus. The host first writes a packed selector word into the address register: an enable flag, a bus number, a device number, a function number and a dword register index. It then reads or writes the data port. Each data-port access with the enable flag set produces exactly one request on a downstream request/response interface. The slave access is held, with ready low, until the matching response returns.

Byte and halfword configuration writes go through byte aliases of the data port (port offset plus the low two bits of the register offset). The slave byte enables pick the lanes, and they are passed downstream unchanged, so the target updates only those lanes. A data-port read always returns the full dword. The host obtains a narrow value by shifting right by eight times the low offset bits and masking to 8 or 16 bits.

A single state machine drives each access. ST_IDLE accepts a strobe. It moves to ST_REQ when the access is a data-port access with the enable flag set, and to ST_ACK for any other access. ST_REQ issues the one-cycle request and moves to ST_ACK if the response is already present, otherwise to ST_WAIT. ST_WAIT moves to ST_ACK when the response arrives. ST_ACK raises ready for one cycle and returns to ST_IDLE.

Top module: `cfg_window`

## Requirements
- R1: After reset, s_ready and req_valid are low and the address register reads 0x00000000.
- R2: The address register sits at byte offset 0x28. Its fields are: enable in bit 31, bus in bits 23:16, device in bits 15:11, function in bits 10:8 and dword register index in bits 7:2. The request carries these values on req_bus, req_dev, req_fn and req_reg.
- R3: The address register reads back what was written, with bits 30:24 and 1:0 reading as zero. A write updates only the byte lanes whose s_be bit is set (bit i covers data bits 8i+7:8i). The register does not change without a write to offset 0x28.
- R4: Byte offsets 0x2C to 0x2F all select the data port. With the enable bit set, each data-port access produces exactly one req_valid pulse, one cycle long.
- R5: With the enable bit clear, a data-port read returns 0xFFFFFFFF and a data-port write is dropped. Neither produces a request.
- R6: A data-port read holds s_ready low until rsp_valid is seen. s_ready rises on the next cycle, and s_rdata then holds the full response dword whichever alias was used.
- R7: A data-port write forwards s_wdata and s_be unchanged on req_wdata and req_be, with req_write high. It completes one cycle after rsp_valid, so only the enabled lanes of the target dword change.
- R8: Any other offset reads as zero, and writes to it have no effect and produce no request.
- R9: Every access is acknowledged by a single-cycle s_ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_sel | input | 1 | Access strobe, held until s_ready |
| s_write | input | 1 | 1 = write, 0 = read |
| s_addr | input | ADDR_W | Byte offset inside the window |
| s_wdata | input | 32 | Write data |
| s_be | input | 4 | Byte enables |
| s_rdata | output | 32 | Read data, valid while s_ready |
| s_ready | output | 1 | Access completion pulse |
| req_valid | output | 1 | Downstream request pulse |
| req_write | output | 1 | Request is a write |
| req_bus | output | 8 | Target bus number |
| req_dev | output | 5 | Target device number |
| req_fn | output | 3 | Target function number |
| req_reg | output | 6 | Target dword register index |
| req_be | output | 4 | Lanes to update on a write |
| req_wdata | output | 32 | Write data for the target |
| rsp_valid | input | 1 | Downstream completion pulse |
| rsp_rdata | input | 32 | Read data from the target |

## Verification
The assertions assume that the host holds its strobe and operands steady until ready and does not rewrite the address register while a data-port access is open. They also assume that rsp_valid arrives only once, after a request and while the machine is in ST_REQ or ST_WAIT. The bench drives one access at a time through a task that waits for ready before it drops the strobe. Its responder answers each request exactly once, after a latency of 0 to 3 cycles that changes from one request to the next.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;
    localparam int BUS_W   = 8;
    localparam int DEV_W   = 5;
    localparam int FN_W    = 3;
    localparam int REG_W   = 6;
    localparam int EN_POS  = 31;
    localparam int REG_LSB = 2;
    localparam int FN_LSB  = REG_LSB + REG_W;
    localparam int DEV_LSB = FN_LSB + FN_W;
    localparam int BUS_LSB = DEV_LSB + DEV_W;
    localparam logic [DATA_W-1:0] ADDR_KEEP =
        (DATA_W'(1) << EN_POS) | ((DATA_W'(1) << (BUS_LSB + BUS_W)) - (DATA_W'(1) << REG_LSB));

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_ACK
    } seq_state_e;
endpackage

// File: rtl/cfgw_addr_reg.sv
module cfgw_addr_reg
    import cfgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BE_W-1:0]   wbe,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic              en,
    output logic [BUS_W-1:0]  bus,
    output logic [DEV_W-1:0]  dev,
    output logic [FN_W-1:0]   fn,
    output logic [REG_W-1:0]  regi
);
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < BE_W; i++) begin
                if (wbe[i]) q[8*i +: 8] <= wdata[8*i +: 8] & ADDR_KEEP[8*i +: 8];
            end
        end
    end

    assign value = q;
    assign en    = q[EN_POS];
    assign bus   = q[BUS_LSB +: BUS_W];
    assign dev   = q[DEV_LSB +: DEV_W];
    assign fn    = q[FN_LSB +: FN_W];
    assign regi  = q[REG_LSB +: REG_W];

    // R3: contents change only on a register write
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(value));
endmodule

// File: rtl/cfgw_seq.sv
module cfgw_seq
    import cfgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_sel,
    input  logic              s_write,
    input  logic              hit_addr,
    input  logic              hit_data,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [BE_W-1:0]   s_be,
    input  logic              en,
    input  logic [DATA_W-1:0] ar_value,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_rdata,
    output logic              ar_wr,
    output logic              s_ready,
    output logic [DATA_W-1:0] s_rdata,
    output logic              req_valid,
    output logic              req_write,
    output logic [DATA_W-1:0] req_wdata,
    output logic [BE_W-1:0]   req_be
);
    seq_state_e state, state_nx;
    logic       accept;
    logic [DATA_W-1:0] rdata_q;

    assign accept = (state == ST_IDLE) && s_sel;
    assign ar_wr  = accept && s_write && hit_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (s_sel) state_nx = (hit_data && en) ? ST_REQ : ST_ACK;
            ST_REQ:  state_nx = rsp_valid ? ST_ACK : ST_WAIT;
            ST_WAIT: if (rsp_valid) state_nx = ST_ACK;
            ST_ACK:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q   <= '0;
            req_write <= 1'b0;
            req_wdata <= '0;
            req_be    <= '0;
        end else if (accept) begin
            req_write <= s_write;
            req_wdata <= s_wdata;
            req_be    <= s_be;
            if (hit_addr)      rdata_q <= ar_value;
            else if (hit_data) rdata_q <= '1;
            else               rdata_q <= '0;
        end else if ((state == ST_REQ || state == ST_WAIT) && rsp_valid) begin
            rdata_q <= req_write ? '0 : rsp_rdata;
        end
    end

    assign s_ready   = (state == ST_ACK);
    assign req_valid = (state == ST_REQ);
    assign s_rdata   = rdata_q;

    // R4: one request cycle per access
    a_r4_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);
    // R5: a request is only issued with the enable flag set
    a_r5_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> en);
    // R6: completion follows the response by one cycle
    a_r6_ack_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_REQ || state == ST_WAIT) && rsp_valid) |=> s_ready);
    // R6: no completion while the response is outstanding
    a_r6_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !rsp_valid) |=> !s_ready);
    // R9: ready is a single-cycle pulse
    a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);
endmodule

// File: rtl/cfg_window.sv
module cfg_window
    import cfgw_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int ADDR_REG_OFS  = 'h28,
    parameter int DATA_PORT_OFS = 'h2C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_sel,
    input  logic              s_write,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_be,
    output logic [31:0]       s_rdata,
    output logic              s_ready,
    output logic              req_valid,
    output logic              req_write,
    output logic [7:0]        req_bus,
    output logic [4:0]        req_dev,
    output logic [2:0]        req_fn,
    output logic [5:0]        req_reg,
    output logic [3:0]        req_be,
    output logic [31:0]       req_wdata,
    input  logic              rsp_valid,
    input  logic [31:0]       rsp_rdata
);
    localparam logic [ADDR_W-1:0] AR_OFS = ADDR_W'(ADDR_REG_OFS);
    localparam logic [ADDR_W-1:0] DP_OFS = ADDR_W'(DATA_PORT_OFS);

    logic              hit_addr, hit_data, ar_wr, en;
    logic [DATA_W-1:0] ar_value;

    assign hit_addr = (s_addr == AR_OFS);
    assign hit_data = (s_addr[ADDR_W-1:2] == DP_OFS[ADDR_W-1:2]);

    cfgw_addr_reg u_areg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ar_wr),
        .wbe   (s_be),
        .wdata (s_wdata),
        .value (ar_value),
        .en    (en),
        .bus   (req_bus),
        .dev   (req_dev),
        .fn    (req_fn),
        .regi  (req_reg)
    );

    cfgw_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_sel     (s_sel),
        .s_write   (s_write),
        .hit_addr  (hit_addr),
        .hit_data  (hit_data),
        .s_wdata   (s_wdata),
        .s_be      (s_be),
        .en        (en),
        .ar_value  (ar_value),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .ar_wr     (ar_wr),
        .s_ready   (s_ready),
        .s_rdata   (s_rdata),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .req_be    (req_be)
    );
endmodule

// File: tb/tb_cfg_window.sv
module tb_cfg_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_sel = 1'b0, s_write = 1'b0;
    logic [7:0]  s_addr = '0;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_be = '0;
    logic [31:0] s_rdata;
    logic        s_ready, req_valid, req_write;
    logic [7:0]  req_bus;
    logic [4:0]  req_dev;
    logic [2:0]  req_fn;
    logic [5:0]  req_reg;
    logic [3:0]  req_be;
    logic [31:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_rdata = '0;

    always #2.5 clk = ~clk;

    cfg_window dut (.*);

    int checks = 0, errors = 0, cycles = 0;
    int req_cnt = 0, stall_bad = 0, ready_bad = 0;
    logic [31:0] tmem [128];
    logic [31:0] expm [128];
    logic        pend = 1'b0;
    logic [1:0]  lat = '0, lat_rot = '0;
    logic [6:0]  pidx = '0;
    logic [31:0] last_field = '0;
    logic        prev_ready = 1'b0;

    function automatic logic [31:0] init_val(int i);
        return 32'h5A00_0000 + i * 32'h0102_0304;
    endfunction
    function automatic int tidx(logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [5:0] r);
        return {b[0], d[1:0], f[0], r[2:0]};
    endfunction

    // target responder and request monitor
    always @(posedge clk) begin
        rsp_valid <= 1'b0;
        if (s_ready && pend) stall_bad++;
        if (s_ready && prev_ready) ready_bad++;
        prev_ready = s_ready;
        if (req_valid) begin
            req_cnt++;
            last_field = {req_write, 7'd0, req_bus, req_dev, req_fn, req_reg, 2'b00};
            pidx <= 7'(tidx(req_bus, req_dev, req_fn, req_reg));
            if (req_write) begin
                for (int k = 0; k < 4; k++)
                    if (req_be[k]) tmem[tidx(req_bus, req_dev, req_fn, req_reg)][8*k +: 8] = req_wdata[8*k +: 8];
            end
            pend <= 1'b1;
            lat <= lat_rot;
            lat_rot <= lat_rot + 2'd1;
        end else if (pend) begin
            if (lat == 0) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= tmem[pidx];
                pend <= 1'b0;
            end else begin
                lat <= lat - 2'd1;
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                       input logic [3:0] be, output logic [31:0] rd);
        int n = 0;
        @(negedge clk);
        s_sel = 1'b1; s_write = wr; s_addr = a; s_wdata = wd; s_be = be;
        forever begin
            @(negedge clk);
            n++;
            if (s_ready || n > 50) break;
        end
        rd = s_rdata;
        if (n > 50) chk("R9 access timeout", 32'd0, 32'd1);
        s_sel = 1'b0;
    endtask

    function automatic logic [31:0] sel_word(int b, int d, int f, int r, bit e);
        return (32'(e) << 31) | (32'(b) << 16) | (32'(d) << 11) | (32'(f) << 8) | (32'(r) << 2) | 32'h3;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] rd, nv;
        int n0, ix;
        for (int i = 0; i < 128; i++) begin
            tmem[i] = init_val(i);
            expm[i] = init_val(i);
        end
        repeat (3) @(negedge clk);
        chk("R1 ready after reset", {31'd0, s_ready}, 32'd0);
        chk("R1 req_valid after reset", {31'd0, req_valid}, 32'd0);
        rst_n = 1'b1;
        acc(1'b0, 8'h28, '0, 4'hF, rd);
        chk("R1 address register reset", rd, 32'd0);

        // R3: readback mask and byte enables
        acc(1'b1, 8'h28, 32'hFFFF_FFFF, 4'hF, rd);
        acc(1'b0, 8'h28, '0, 4'hF, rd);
        chk("R3 readback mask", rd, 32'h80FF_FFFC);
        acc(1'b1, 8'h28, 32'h0, 4'b0010, rd);
        acc(1'b0, 8'h28, '0, 4'hF, rd);
        chk("R3 byte enable lane", rd, 32'h80FF_00FC);

        // R8: other offsets
        acc(1'b0, 8'h00, '0, 4'hF, rd);
        chk("R8 other offset reads zero", rd, 32'd0);
        n0 = req_cnt;
        acc(1'b1, 8'h30, 32'h1234_5678, 4'hF, rd);
        acc(1'b0, 8'h28, '0, 4'hF, rd);
        chk("R8 other write leaves address register", rd, 32'h80FF_00FC);
        chk("R8 no request", 32'(req_cnt), 32'(n0));

        // R5: disabled data port
        acc(1'b1, 8'h28, sel_word(1, 2, 1, 5, 1'b0), 4'hF, rd);
        n0 = req_cnt;
        acc(1'b0, 8'h2C, '0, 4'hF, rd);
        chk("R5 disabled read all ones", rd, 32'hFFFF_FFFF);
        acc(1'b1, 8'h2C, 32'hDEAD_BEEF, 4'hF, rd);
        chk("R5 disabled no request", 32'(req_cnt), 32'(n0));
        acc(1'b1, 8'h28, sel_word(1, 2, 1, 5, 1'b1), 4'hF, rd);
        acc(1'b0, 8'h2C, '0, 4'hF, rd);
        chk("R5 dropped write left target", rd, expm[tidx(1, 2, 1, 5)]);

        // R2 R4 R6: sweep every modelled target dword
        for (int b = 0; b < 2; b++)
            for (int d = 0; d < 4; d++)
                for (int f = 0; f < 2; f++)
                    for (int r = 0; r < 8; r++) begin
                        acc(1'b1, 8'h28, sel_word(b, d, f, r, 1'b1), 4'hF, rd);
                        n0 = req_cnt;
                        acc(1'b0, 8'h2C + 8'(r % 4), '0, 4'hF, rd);
                        chk("R6 read dword", rd, expm[tidx(8'(b), 5'(d), 3'(f), 6'(r))]);
                        chk("R2 request fields",
                            last_field, {8'd0, 8'(b), 5'(d), 3'(f), 6'(r), 2'b00});
                        chk("R4 one request per access", 32'(req_cnt - n0), 32'd1);
                    end

        // R7: full, byte and halfword writes
        for (int t = 0; t < 8; t++) begin
            int b = t % 2, d = t % 4, f = (t / 2) % 2, r = t;
            ix = tidx(8'(b), 5'(d), 3'(f), 6'(r));
            acc(1'b1, 8'h28, sel_word(b, d, f, r, 1'b1), 4'hF, rd);
            nv = 32'hC0DE_0000 + 32'(t) * 32'h1111;
            acc(1'b1, 8'h2C, nv, 4'hF, rd);
            expm[ix] = nv;
            chk("R7 write request flag", last_field[31:24], 8'h80);
            acc(1'b0, 8'h2C, '0, 4'hF, rd);
            chk("R7 full write", rd, expm[ix]);
            for (int ln = 0; ln < 4; ln++) begin
                logic [7:0] bv = 8'(8'h30 + t * 4 + ln);
                acc(1'b1, 8'h2C + 8'(ln), 32'(bv) << (8 * ln), 4'b0001 << ln, rd);
                expm[ix][8*ln +: 8] = bv;
                acc(1'b0, 8'h2C + 8'(ln), '0, 4'hF, rd);
                chk("R7 byte lane merge", rd, expm[ix]);
                chk("R6 narrow extract", (rd >> (8 * ln)) & 32'hFF, 32'(bv));
            end
            for (int h = 0; h < 4; h += 2) begin
                logic [15:0] hv = 16'(16'hA500 + t * 16 + h);
                acc(1'b1, 8'h2C + 8'(h), 32'(hv) << (8 * h), 4'b0011 << h, rd);
                expm[ix][8*h +: 16] = hv;
                acc(1'b0, 8'h2E, '0, 4'hF, rd);
                chk("R7 halfword merge", rd, expm[ix]);
                chk("R6 halfword extract", (rd >> (8 * h)) & 32'hFFFF, 32'(hv));
            end
        end

        repeat (4) @(negedge clk);
        chk("R6 ready never during outstanding response", 32'(stall_bad), 32'd0);
        chk("R9 ready single cycle", 32'(ready_bad), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule